// File: doc/BRIEF.md
# Lane Alignment Character Monitor

This block sits on one receive lane after character decoding. It watches the octet stream for the lane alignment control character and keeps a running octet index within the multi-frame. It also tracks where the end of the multi-frame is taken to be. The multi-frame length is K_FRAMES × F_OCTETS octets, and the index counts modulo that length.

An alignment character that lands where the multi-frame is expected to end confirms the current alignment. One that lands elsewhere is treated with caution. A single such character only marks its position as a candidate. A second one at that same position then moves the multi-frame boundary there, provided no alignment character turned up at the expected end in between.

A frame realignment from the neighbouring frame-alignment logic clears the aligned flag and arms a forced mode. In that mode the very first alignment character at an unexpected position moves the boundary at once.

Top module: `lane_align_monitor`

## Requirements
- R1: After reset, mf_index is 0, lane_aligned is 0 and lane_realign is 0.
- R2: Each cycle with oct_valid high advances mf_index by one, wrapping from K_FRAMES×F_OCTETS−1 to 0. With oct_valid low, mf_index holds. Realignment is the only exception.
- R3: An octet is an alignment character only when oct_is_ctrl is 1 and oct_data is 8'h7C. It is well placed when frame_octet equals F_OCTETS−1 and misplaced otherwise. Data 8'h7C with oct_is_ctrl 0 is ordinary data.
- R4: An alignment character at index K_FRAMES×F_OCTETS−1 never causes a realignment. If it is well placed, lane_aligned is 1 on the next cycle.
- R5: A single well-placed alignment character at any other index only records that index as a candidate. The index keeps counting and there is no pulse.
- R6: A second well-placed alignment character at the recorded candidate index realigns the lane. One cycle later, lane_realign is 1, mf_index is 0 and lane_aligned is 1.
- R7: An alignment character, well placed or misplaced, at the expected end index discards the pending candidate.
- R8: Without forced mode, a misplaced alignment character at an unexpected index neither commits nor discards the candidate.
- R9: A frame_realign pulse makes lane_aligned 0 on the next cycle and arms forced mode. In forced mode, the first alignment character of either kind at an unexpected index realigns the lane at once, with the results of R6.
- R10: An alignment character at the expected end index leaves forced mode. After that, realignment needs two characters again.
- R11: lane_realign is high for exactly the cycle after a realigning octet, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_valid | input | 1 | Octet strobe |
| oct_data | input | 8 | Decoded octet value |
| oct_is_ctrl | input | 1 | Octet is a control character |
| frame_octet | input | FOW | Octet position within the frame, from frame alignment |
| frame_realign | input | 1 | Pulse: frame alignment has just moved |
| mf_index | output | MIW | Multi-frame index the next octet takes |
| lane_aligned | output | 1 | Lane alignment confirmed |
| lane_realign | output | 1 | One-cycle pulse: multi-frame boundary moved |

## Verification
Every result is registered once. An octet presented in one cycle therefore shows its effect on mf_index, lane_aligned and lane_realign right after the next rising edge. A frame_realign pulse acts on lane_aligned with the same single-cycle delay.

The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and all three outputs are compared against it on the following falling edge. Directed checks are sampled at that same falling edge, immediately after the octet they concern.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam logic [7:0] ALIGN_CODE = 8'h7C;

    typedef enum logic [1:0] {
        OCT_IDLE  = 2'd0,
        OCT_DATA  = 2'd1,
        OCT_A_OK  = 2'd2,
        OCT_A_BAD = 2'd3
    } oct_class_e;

endpackage

// File: rtl/lam_detect.sv
module lam_detect #(
    parameter  int F_OCTETS = 2,
    localparam int FOW      = (F_OCTETS > 1) ? $clog2(F_OCTETS) : 1
) (
    input  logic                 oct_valid,
    input  logic [7:0]           oct_data,
    input  logic                 oct_is_ctrl,
    input  logic [FOW-1:0]       frame_octet,
    output lam_pkg::oct_class_e  oct_class
);
    localparam logic [FOW-1:0] FRAME_LAST = FOW'(F_OCTETS - 1);

    logic is_align;
    logic at_frame_end;

    always_comb begin
        is_align     = oct_is_ctrl && (oct_data == lam_pkg::ALIGN_CODE);
        at_frame_end = (frame_octet == FRAME_LAST);
        if (!oct_valid) begin
            oct_class = lam_pkg::OCT_IDLE;
        end else if (!is_align) begin
            oct_class = lam_pkg::OCT_DATA;
        end else if (at_frame_end) begin
            oct_class = lam_pkg::OCT_A_OK;
        end else begin
            oct_class = lam_pkg::OCT_A_BAD;
        end
    end
endmodule

// File: rtl/lam_track.sv
module lam_track #(
    parameter  int MF_LEN = 8,
    localparam int MIW    = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lam_pkg::oct_class_e oct_class,
    input  logic                frame_realign,
    output logic [MIW-1:0]      mf_index,
    output logic                lane_aligned,
    output logic                lane_realign
);
    localparam logic [MIW-1:0] LAST_IDX = MIW'(MF_LEN - 1);

    typedef struct packed {
        logic [MIW-1:0] idx;
        logic           aligned;
        logic           realign;
        logic           cand_vld;
        logic [MIW-1:0] cand_pos;
        logic           force_arm;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic           at_end;
    logic           is_align;
    logic           well_placed;
    logic           commit;
    logic [MIW-1:0] step_idx;

    always_comb begin
        st_d        = st_q;
        st_d.realign = 1'b0;
        at_end      = (st_q.idx == LAST_IDX);
        step_idx    = at_end ? '0 : st_q.idx + 1'b1;
        is_align    = (oct_class == lam_pkg::OCT_A_OK) || (oct_class == lam_pkg::OCT_A_BAD);
        well_placed = (oct_class == lam_pkg::OCT_A_OK);
        commit      = 1'b0;

        if (is_align) begin
            if (at_end) begin
                // expected boundary: confirm, drop candidate and forced mode
                st_d.idx       = '0;
                st_d.cand_vld  = 1'b0;
                st_d.force_arm = 1'b0;
                if (well_placed) begin
                    st_d.aligned = 1'b1;
                end
            end else if (st_q.force_arm) begin
                commit = 1'b1;
            end else if (well_placed && st_q.cand_vld && (st_q.cand_pos == st_q.idx)) begin
                commit = 1'b1;
            end else begin
                if (well_placed) begin
                    st_d.cand_vld = 1'b1;
                    st_d.cand_pos = st_q.idx;
                end
                st_d.idx = step_idx;
            end
        end else if (oct_class == lam_pkg::OCT_DATA) begin
            st_d.idx = step_idx;
        end

        if (commit) begin
            st_d.idx       = '0;
            st_d.realign   = 1'b1;
            st_d.aligned   = 1'b1;
            st_d.cand_vld  = 1'b0;
            st_d.force_arm = 1'b0;
        end

        if (frame_realign) begin
            st_d.aligned   = 1'b0;
            st_d.force_arm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mf_index     = st_q.idx;
    assign lane_aligned = st_q.aligned;
    assign lane_realign = st_q.realign;
endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor #(
    parameter  int K_FRAMES = 4,
    parameter  int F_OCTETS = 2,
    localparam int MF_LEN   = K_FRAMES * F_OCTETS,
    localparam int MIW      = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
    localparam int FOW      = (F_OCTETS > 1) ? $clog2(F_OCTETS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           oct_valid,
    input  logic [7:0]     oct_data,
    input  logic           oct_is_ctrl,
    input  logic [FOW-1:0] frame_octet,
    input  logic           frame_realign,
    output logic [MIW-1:0] mf_index,
    output logic           lane_aligned,
    output logic           lane_realign
);
    lam_pkg::oct_class_e oct_class;

    lam_detect #(.F_OCTETS(F_OCTETS)) u_detect (
        .oct_valid   (oct_valid),
        .oct_data    (oct_data),
        .oct_is_ctrl (oct_is_ctrl),
        .frame_octet (frame_octet),
        .oct_class   (oct_class)
    );

    lam_track #(.MF_LEN(MF_LEN)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .oct_class     (oct_class),
        .frame_realign (frame_realign),
        .mf_index      (mf_index),
        .lane_aligned  (lane_aligned),
        .lane_realign  (lane_realign)
    );
endmodule

// File: rtl/lane_align_monitor_chk.sv
module lane_align_monitor_chk #(
    parameter  int K_FRAMES = 4,
    parameter  int F_OCTETS = 2,
    localparam int MF_LEN   = K_FRAMES * F_OCTETS,
    localparam int MIW      = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
    localparam int FOW      = (F_OCTETS > 1) ? $clog2(F_OCTETS) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           oct_valid,
    input logic [7:0]     oct_data,
    input logic           oct_is_ctrl,
    input logic [FOW-1:0] frame_octet,
    input logic           frame_realign,
    input logic [MIW-1:0] mf_index,
    input logic           lane_aligned,
    input logic           lane_realign
);
    localparam logic [MIW-1:0] LAST_IDX   = MIW'(MF_LEN - 1);
    localparam logic [FOW-1:0] FRAME_LAST = FOW'(F_OCTETS - 1);

    logic [MIW-1:0] exp_step;
    logic           align_seen;

    always_comb begin
        exp_step   = (mf_index == LAST_IDX) ? '0 : mf_index + 1'b1;
        align_seen = oct_is_ctrl && (oct_data == 8'h7C);
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oct_valid |=> $stable(mf_index));

    // R2
    data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && !align_seen) |=> (mf_index == $past(exp_step)));

    // R3
    ctrl_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && !oct_is_ctrl) |=> !lane_realign);

    // R4
    end_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && align_seen && (frame_octet == FRAME_LAST) &&
         (mf_index == LAST_IDX) && !frame_realign)
        |=> (lane_aligned && !lane_realign && (mf_index == '0)));

    // R6
    realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_realign |-> (mf_index == '0));

    // R9
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_realign |=> !lane_aligned);

    // R11
    no_octet_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oct_valid |=> !lane_realign);
endmodule

bind lane_align_monitor lane_align_monitor_chk #(
    .K_FRAMES(K_FRAMES),
    .F_OCTETS(F_OCTETS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .oct_valid     (oct_valid),
    .oct_data      (oct_data),
    .oct_is_ctrl   (oct_is_ctrl),
    .frame_octet   (frame_octet),
    .frame_realign (frame_realign),
    .mf_index      (mf_index),
    .lane_aligned  (lane_aligned),
    .lane_realign  (lane_realign)
);

// File: tb/lane_align_monitor_bench.sv
`timescale 1ns/1ps
module lane_align_monitor_bench;
    localparam int K  = 4;
    localparam int F  = 2;
    localparam int MF = K * F;
    localparam int MIW = (MF > 1) ? $clog2(MF) : 1;
    localparam int FOW = (F > 1) ? $clog2(F) : 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           oct_valid = 1'b0;
    logic [7:0]     oct_data = 8'h00;
    logic           oct_is_ctrl = 1'b0;
    logic [FOW-1:0] frame_octet = '0;
    logic           frame_realign = 1'b0;
    logic [MIW-1:0] mf_index;
    logic           lane_aligned;
    logic           lane_realign;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lane_align_monitor #(.K_FRAMES(K), .F_OCTETS(F)) u_lane_align_monitor (
        .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_data(oct_data),
        .oct_is_ctrl(oct_is_ctrl), .frame_octet(frame_octet),
        .frame_realign(frame_realign), .mf_index(mf_index),
        .lane_aligned(lane_aligned), .lane_realign(lane_realign)
    );

    // behavioural reference model
    int m_idx = 0, m_al = 0, m_rl = 0, m_cand = -1, m_force = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_al = 0; m_rl = 0; m_cand = -1; m_force = 0;
        end else begin
            bit a, good, move;
            m_rl = 0;
            move = 0;
            if (oct_valid) begin
                a    = oct_is_ctrl && (oct_data == 8'h7C);
                good = (int'(frame_octet) == F - 1);
                if (a && m_idx == MF - 1) begin
                    m_cand = -1; m_force = 0; m_idx = 0;
                    if (good) m_al = 1;
                end else if (a && (m_force != 0 || (good && m_cand == m_idx))) begin
                    move = 1;
                end else begin
                    if (a && good) m_cand = m_idx;
                    m_idx = (m_idx + 1) % MF;
                end
                if (move) begin
                    m_idx = 0; m_rl = 1; m_al = 1; m_force = 0; m_cand = -1;
                end
            end
            if (frame_realign) begin
                m_al = 0; m_force = 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 mf_index vs model", int'(mf_index), m_idx);
            check("R4 lane_aligned vs model", int'(lane_aligned), m_al);
            check("R11 lane_realign vs model", int'(lane_realign), m_rl);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    // one octet, entered and left at a falling edge
    task automatic send(logic [7:0] d, logic c, int fpos);
        oct_valid = 1'b1; oct_data = d; oct_is_ctrl = c;
        frame_octet = FOW'(fpos);
        @(negedge clk);
        oct_valid = 1'b0; oct_is_ctrl = 1'b0; oct_data = 8'h00;
    endtask

    task automatic data(int n);
        for (int i = 0; i < n; i++) send(8'h3A + 8'(i), 1'b0, i % F);
    endtask

    task automatic a_ok();  send(8'h7C, 1'b1, F - 1); endtask
    task automatic a_bad(); send(8'h7C, 1'b1, 0);     endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fr_pulse();
        frame_realign = 1'b1;
        @(negedge clk);
        frame_realign = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mf_index after reset", int'(mf_index), 0);
        check("R1 lane_aligned after reset", int'(lane_aligned), 0);
        check("R1 lane_realign after reset", int'(lane_realign), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: confirm at expected end
        data(7); a_ok();
        check("R4 aligned after end char", int'(lane_aligned), 1);
        check("R4 no realign at end", int'(lane_realign), 0);
        idle(3);
        check("R2 index held while idle", int'(mf_index), 0);

        // R5 then R6
        data(3); a_ok();
        check("R5 single char only counts", int'(mf_index), 4);
        check("R5 no pulse on single char", int'(lane_realign), 0);
        data(7); a_ok();
        check("R6 realign pulse", int'(lane_realign), 1);
        check("R6 index to 0", int'(mf_index), 0);
        idle(1);
        check("R11 pulse lasts one cycle", int'(lane_realign), 0);

        // R7: end char between the two cancels
        data(3); a_ok(); data(3); a_ok(); data(3); a_ok();
        check("R7 cancelled candidate no realign", int'(lane_realign), 0);
        check("R7 index continues", int'(mf_index), 4);
        data(4);

        // R8: misplaced chars neither commit nor clear
        data(3); a_bad(); data(7); a_bad();
        check("R8 misplaced no realign", int'(lane_realign), 0);
        check("R8 index continues", int'(mf_index), 4);
        data(7); a_ok();
        check("R8 candidate kept, commit now", int'(lane_realign), 1);

        // R3: 0x7C without control flag is data
        data(3); send(8'h7C, 1'b0, F - 1); data(7); send(8'h7C, 1'b0, F - 1);
        check("R3 plain 0x7C no realign", int'(lane_realign), 0);
        check("R3 plain 0x7C counts as data", int'(mf_index), 4);
        data(4);

        // R9: forced realignment
        fr_pulse();
        check("R9 aligned dropped", int'(lane_aligned), 0);
        data(2); a_bad();
        check("R9 forced realign pulse", int'(lane_realign), 1);
        check("R9 forced index 0", int'(mf_index), 0);

        // R10: end char leaves forced mode
        fr_pulse();
        data(7); a_bad();
        check("R10 misplaced end char keeps unaligned", int'(lane_aligned), 0);
        data(2); a_ok();
        check("R10 single char after exit no realign", int'(lane_realign), 0);
        check("R10 index continues", int'(mf_index), 3);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            frame_realign = ($urandom_range(0, 59) == 0);
            oct_valid   = (r < 80);
            if (r < 20) begin
                oct_data = 8'h7C; oct_is_ctrl = 1'b1;
            end else begin
                oct_data = 8'($urandom); oct_is_ctrl = ($urandom_range(0, 6) == 0);
            end
            frame_octet = FOW'($urandom_range(0, F - 1));
            @(negedge clk);
        end
        oct_valid = 1'b0; frame_realign = 1'b0;
        idle(2);
        finish_run();
    end
endmodule